// File: doc/BRIEF.md
# Dual Data Address Breakpoint Unit

The block sits beside a load/store pipeline and watches the effective address of every data access. Two programmable breakpoint addresses, A and B, feed a comparator set that recognises one of four conditions: an exact hit on A, a hit on either A or B, an address strictly between A and B, or an address outside that span. All compares work on double-word granularity, so the lowest three address bits never take part.

A qualified match has two effects. It raises a one-cycle data-access exception request with vector offset 0x300. It also records the access in a sticky status flag and in an address capture register. Two watchpoint pins show matches to the outside. When the condition is a single-address condition, each pin follows its own comparator. When the condition is a range condition, only the second pin drives, and it follows the range result. A do-not-signal bit keeps both pins low.

Software programs the unit through a small write port. The port has a 2-bit register select: 0 loads address A, 1 loads address B, 2 loads the control word, and 3 is the status-clear command.

Top module: `dabr_unit`

## Requirements
- R1: With condition code 0 (control bits [3:2] = 00), an access matches only when its masked address equals A; an access at B does not match.
- R2: With condition code 1, an access matches when its masked address equals A or equals B.
- R3: With condition code 2, an access matches only when A < masked address < B, strictly; addresses equal to A or B do not match.
- R4: With condition code 3, an access matches when the masked address is below A or above B.
- R5: A read access (acc_write_i = 0) can match only when control bit 0 (read enable) is set. A write access can match only when control bit 1 (write enable) is set.
- R6: Address bits [2:0] are ignored in every compare.
- R7: A match on an access presented in one cycle makes exc_req_o high for exactly the following cycle, with exc_vec_o = 0x0300. exc_vec_o is 0 when no request is raised.
- R8: The first match while the hit flag is clear sets hit_flag_o and loads cap_addr_o with the full access address. While the flag stays set, later matches still raise exc_req_o but leave the flag and the captured address unchanged.
- R9: A register write with select 3 and data bit 0 set clears hit_flag_o on that edge. If a match occurs in the same cycle, the match wins: the flag stays set and the address is captured.
- R10: Under condition codes 0 and 1, wp_a_o pulses for a match on A and wp_b_o pulses for a match on B (code 1 only), each one cycle after the access.
- R11: Under condition codes 2 and 3, wp_a_o stays low and wp_b_o pulses when the range condition holds.
- R12: While control bit 4 (do-not-signal) is set, both watchpoint pins stay low, and exception requests and capture are unaffected.
- R13: After reset, all outputs are 0, both addresses are 0, and both enables are clear, so no access matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | A data access is presented this cycle |
| acc_write_i | input | 1 | 1 for store, 0 for load |
| acc_addr_i | input | AW | Effective address of the access |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 A, 1 B, 2 control, 3 clear |
| cfg_data_i | input | AW | Write data |
| exc_req_o | output | 1 | Data-access exception request pulse |
| exc_vec_o | output | 16 | Vector offset, 0x0300 when requesting |
| hit_flag_o | output | 1 | Sticky breakpoint cause flag |
| cap_addr_o | output | AW | Captured matching address |
| wp_a_o | output | 1 | First watchpoint pin |
| wp_b_o | output | 1 | Second watchpoint pin |

## Verification
The bench builds the unit with AW = 16 and the default three-bit granularity. The narrow address lets directed accesses sit right at a breakpoint, one double word beside it, or at the far ends of the space, so every strict boundary of the range conditions is reached. The bench then walks all four condition codes. It covers both access directions against each enable, the sticky capture when matches arrive back to back, and a clear that lands in the same cycle as a match.

// File: rtl/dabr_pkg.sv
package dabr_pkg;
  typedef enum logic [1:0] {
    COND_EQ_A   = 2'd0,
    COND_EQ_AB  = 2'd1,
    COND_INSIDE = 2'd2,
    COND_OUTSIDE= 2'd3
  } cond_e;

  typedef struct packed {
    logic  no_sig;
    cond_e cond;
    logic  wr_en;
    logic  rd_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam int unsigned VEC_W  = 16;
  localparam logic [VEC_W-1:0] DACC_VEC = 16'h0300;

  localparam logic [1:0] SEL_A     = 2'd0;
  localparam logic [1:0] SEL_B     = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_CLEAR = 2'd3;
endpackage

// File: rtl/dabr_cfg.sv
module dabr_cfg
  import dabr_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] data_i,
  output logic [AW-1:0] addr_a_o,
  output logic [AW-1:0] addr_b_o,
  output ctrl_t         ctrl_o,
  output logic          clear_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_a_o <= '0;
      addr_b_o <= '0;
      ctrl_o   <= '0;
    end else if (wr_i) begin
      unique case (sel_i)
        SEL_A:    addr_a_o <= data_i;
        SEL_B:    addr_b_o <= data_i;
        SEL_CTRL: ctrl_o   <= ctrl_t'(data_i[CTRL_W-1:0]);
        default:  ;
      endcase
    end
  end

  assign clear_o = wr_i && (sel_i == SEL_CLEAR) && data_i[0];
endmodule

// File: rtl/dabr_cmp.sv
module dabr_cmp
  import dabr_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned GRAN_BITS = 3
) (
  input  logic [AW-1:0] ea_i,
  input  logic [AW-1:0] addr_a_i,
  input  logic [AW-1:0] addr_b_i,
  input  cond_e         cond_i,
  output logic          hit_a_o,
  output logic          hit_b_o,
  output logic          in_rng_o,
  output logic          out_rng_o,
  output logic          match_o
);
  localparam int unsigned NCH = 2;
  localparam logic [AW-1:0] MASK = {{(AW-GRAN_BITS){1'b1}}, {GRAN_BITS{1'b0}}};

  logic [AW-1:0] ea_m;
  logic [AW-1:0] bp_m [NCH];
  logic [NCH-1:0] eq;
  logic [NCH-1:0] ea_gt;
  logic [NCH-1:0] ea_lt;

  assign ea_m    = ea_i & MASK;
  assign bp_m[0] = addr_a_i & MASK;
  assign bp_m[1] = addr_b_i & MASK;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign eq[i]    = (ea_m == bp_m[i]);
    assign ea_gt[i] = (ea_m >  bp_m[i]);
    assign ea_lt[i] = (ea_m <  bp_m[i]);
  end

  assign hit_a_o   = eq[0];
  assign hit_b_o   = eq[1];
  assign in_rng_o  = ea_gt[0] && ea_lt[1];
  assign out_rng_o = ea_lt[0] || ea_gt[1];

  always_comb begin
    unique case (cond_i)
      COND_EQ_A:    match_o = eq[0];
      COND_EQ_AB:   match_o = eq[0] || eq[1];
      COND_INSIDE:  match_o = in_rng_o;
      default:      match_o = out_rng_o;
    endcase
  end
endmodule

// File: rtl/dabr_capture.sv
module dabr_capture #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic          clear_i,
  input  logic [AW-1:0] addr_i,
  output logic          flag_o,
  output logic [AW-1:0] cap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      cap_o  <= '0;
    end else if (hit_i && (!flag_o || clear_i)) begin
      flag_o <= 1'b1;
      cap_o  <= addr_i;
    end else if (clear_i) begin
      flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dabr_unit.sv
module dabr_unit
  import dabr_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned GRAN_BITS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic             acc_write_i,
  input  logic [AW-1:0]    acc_addr_i,
  input  logic             cfg_wr_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [AW-1:0]    cfg_data_i,
  output logic             exc_req_o,
  output logic [VEC_W-1:0] exc_vec_o,
  output logic             hit_flag_o,
  output logic [AW-1:0]    cap_addr_o,
  output logic             wp_a_o,
  output logic             wp_b_o
);
  logic [AW-1:0] addr_a, addr_b;
  ctrl_t         ctrl;
  logic          clear;
  logic          hit_a, hit_b, in_rng, out_rng, cmp_match;
  logic          qual, bp_hit, range_mode;
  logic          wpa_d, wpb_d;

  dabr_cfg #(.AW(AW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_wr_i),
    .sel_i    (cfg_sel_i),
    .data_i   (cfg_data_i),
    .addr_a_o (addr_a),
    .addr_b_o (addr_b),
    .ctrl_o   (ctrl),
    .clear_o  (clear)
  );

  dabr_cmp #(.AW(AW), .GRAN_BITS(GRAN_BITS)) u_cmp (
    .ea_i      (acc_addr_i),
    .addr_a_i  (addr_a),
    .addr_b_i  (addr_b),
    .cond_i    (ctrl.cond),
    .hit_a_o   (hit_a),
    .hit_b_o   (hit_b),
    .in_rng_o  (in_rng),
    .out_rng_o (out_rng),
    .match_o   (cmp_match)
  );

  // direction qualifier
  assign qual       = acc_valid_i && (acc_write_i ? ctrl.wr_en : ctrl.rd_en);
  assign bp_hit     = qual && cmp_match;
  assign range_mode = ctrl.cond[1];

  always_comb begin
    wpa_d = 1'b0;
    wpb_d = 1'b0;
    if (qual && !ctrl.no_sig) begin
      if (range_mode) begin
        wpb_d = (ctrl.cond == COND_INSIDE) ? in_rng : out_rng;
      end else begin
        wpa_d = hit_a;
        wpb_d = hit_b && (ctrl.cond == COND_EQ_AB);
      end
    end
  end

  dabr_capture #(.AW(AW)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (bp_hit),
    .clear_i (clear),
    .addr_i  (acc_addr_i),
    .flag_o  (hit_flag_o),
    .cap_o   (cap_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_req_o <= 1'b0;
      exc_vec_o <= '0;
      wp_a_o    <= 1'b0;
      wp_b_o    <= 1'b0;
    end else begin
      exc_req_o <= bp_hit;
      exc_vec_o <= bp_hit ? DACC_VEC : '0;
      wp_a_o    <= wpa_d;
      wp_b_o    <= wpb_d;
    end
  end
endmodule

// File: rtl/dabr_unit_chk.sv
module dabr_unit_chk
  import dabr_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic             acc_write_i,
  input ctrl_t            ctrl,
  input logic             clear,
  input logic             exc_req_o,
  input logic [VEC_W-1:0] exc_vec_o,
  input logic             hit_flag_o,
  input logic [AW-1:0]    cap_addr_o,
  input logic             wp_a_o,
  input logic             wp_b_o
);
  p_req_needs_access_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> $past(acc_valid_i));

  p_dir_enable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> ($past(acc_write_i) ? $past(ctrl.wr_en) : $past(ctrl.rd_en)));

  p_vector_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> (exc_vec_o == DACC_VEC));

  p_flag_on_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> hit_flag_o);

  p_sticky_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hit_flag_o) && !$past(clear)) |-> (hit_flag_o && $stable(cap_addr_o)));

  p_range_pin_a_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl.cond[1]) |-> !wp_a_o);

  p_no_signal_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl.no_sig) |-> !(wp_a_o || wp_b_o));
endmodule

bind dabr_unit dabr_unit_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_write_i (acc_write_i),
  .ctrl        (ctrl),
  .clear       (clear),
  .exc_req_o   (exc_req_o),
  .exc_vec_o   (exc_vec_o),
  .hit_flag_o  (hit_flag_o),
  .cap_addr_o  (cap_addr_o),
  .wp_a_o      (wp_a_o),
  .wp_b_o      (wp_b_o)
);

// File: tb/dabr_unit_tb.sv
`timescale 1ns/1ps
module dabr_unit_tb;
  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] BP_A = 16'h1000;
  localparam logic [AW-1:0] BP_B = 16'h1040;

  // {write, addr, exc, wpa, wpb} under condition code 1, both enables
  localparam int NV = 7;
  localparam logic [AW+3:0] VEC [NV] = '{
    {1'b0, 16'h1000, 1'b1, 1'b1, 1'b0},
    {1'b1, 16'h1007, 1'b1, 1'b1, 1'b0},
    {1'b0, 16'h1008, 1'b0, 1'b0, 1'b0},
    {1'b1, 16'h1040, 1'b1, 1'b0, 1'b1},
    {1'b0, 16'h1047, 1'b1, 1'b0, 1'b1},
    {1'b0, 16'h0FFF, 1'b0, 1'b0, 1'b0},
    {1'b1, 16'h2000, 1'b0, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0, acc_write = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_data = '0;
  logic          exc_req, hit_flag, wp_a, wp_b;
  logic [15:0]   exc_vec;
  logic [AW-1:0] cap_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dabr_unit #(.AW(AW), .GRAN_BITS(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_addr_i(acc_addr),
    .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .exc_req_o(exc_req), .exc_vec_o(exc_vec), .hit_flag_o(hit_flag),
    .cap_addr_o(cap_addr), .wp_a_o(wp_a), .wp_b_o(wp_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic acc(input logic w, input logic [AW-1:0] a);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a;
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  task automatic chk_out(input string tag, input logic e, input logic wa, input logic wb);
    chk({tag, " exc"}, {31'd0, exc_req}, {31'd0, e});
    chk({tag, " vec"}, {16'd0, exc_vec}, e ? 32'h300 : 32'h0);
    chk({tag, " wpa"}, {31'd0, wp_a}, {31'd0, wa});
    chk({tag, " wpb"}, {31'd0, wp_b}, {31'd0, wb});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_out("R13 reset", 1'b0, 1'b0, 1'b0);
    chk("R13 flag", {31'd0, hit_flag}, 32'd0);
    chk("R13 cap", {16'd0, cap_addr}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    acc(1'b0, 16'h0000);
    chk_out("R13 enables clear", 1'b0, 1'b0, 1'b0);

    cfg(2'd0, BP_A);
    cfg(2'd1, BP_B);
    cfg(2'd2, 16'h0007);              // cond 1, rd+wr
    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][AW+3], VEC[i][AW+2:3]);
      chk_out($sformatf("R2/R6/R10 vec%0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R5 direction qualifiers
    cfg(2'd2, 16'h0001);              // cond 0, read only
    acc(1'b1, BP_A);
    chk_out("R5 write blocked", 1'b0, 1'b0, 1'b0);
    acc(1'b0, BP_A);
    chk_out("R5 read allowed", 1'b1, 1'b1, 1'b0);
    cfg(2'd2, 16'h0002);              // cond 0, write only
    acc(1'b0, BP_A);
    chk_out("R5 read blocked", 1'b0, 1'b0, 1'b0);
    acc(1'b1, BP_A);
    chk_out("R5 write allowed", 1'b1, 1'b1, 1'b0);

    // R1 B ignored under cond 0
    cfg(2'd2, 16'h0003);
    acc(1'b0, BP_B);
    chk_out("R1 B ignored", 1'b0, 1'b0, 1'b0);

    // R3 inside strict, R11
    cfg(2'd2, 16'h000B);
    acc(1'b0, BP_A);
    chk_out("R3 lower edge", 1'b0, 1'b0, 1'b0);
    acc(1'b0, 16'h1008);
    chk_out("R3/R11 inside", 1'b1, 1'b0, 1'b1);
    acc(1'b0, 16'h1047);
    chk_out("R3 upper edge", 1'b0, 1'b0, 1'b0);

    // R4 outside, R11
    cfg(2'd2, 16'h000F);
    acc(1'b1, 16'h0FF8);
    chk_out("R4 below", 1'b1, 1'b0, 1'b1);
    acc(1'b1, 16'h103F);
    chk_out("R4 in span", 1'b0, 1'b0, 1'b0);
    acc(1'b1, 16'h1048);
    chk_out("R4/R11 above", 1'b1, 1'b0, 1'b1);

    // R12 do-not-signal
    cfg(2'd2, 16'h001F);
    acc(1'b1, 16'h1048);
    chk_out("R12 pins low", 1'b1, 1'b0, 1'b0);

    // R8 sticky capture
    cfg(2'd3, 16'h0001);
    chk("R9 cleared", {31'd0, hit_flag}, 32'd0);
    acc(1'b0, 16'h0FF3);
    chk("R8 flag set", {31'd0, hit_flag}, 32'd1);
    chk("R8 cap", {16'd0, cap_addr}, 32'h0FF3);
    acc(1'b0, 16'h2000);
    chk("R8 second exc", {31'd0, exc_req}, 32'd1);
    chk("R8 cap kept", {16'd0, cap_addr}, 32'h0FF3);
    chk("R8 flag kept", {31'd0, hit_flag}, 32'd1);

    // R9 clear with same-cycle match
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'd3; cfg_data = 16'h0001;
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 16'h3000;
    @(posedge clk); #1;
    cfg_wr = 1'b0; acc_valid = 1'b0;
    chk("R9 match wins flag", {31'd0, hit_flag}, 32'd1);
    chk("R9 match wins cap", {16'd0, cap_addr}, 32'h3000);
    @(posedge clk); #1;
    chk("R7 single pulse", {31'd0, exc_req}, 32'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule